// File: doc/BRIEF.md
# Security-Filtered Interrupt State Bitmap Bank

This block stores the enable, pending and active state for every shared interrupt of a distributor. Software reaches the state through 32-bit windows. Each kind of state has two windows. In the "set" window a 1 sets a bit, and in the "clear" window a 1 clears it. A read of either window returns the same bitmap.

Every access carries a secure flag. While security is enabled, a non-secure access reaches only some bits: those whose interrupt is in the non-secure group, or whose 2-bit non-secure permission field is high enough for the window being accessed. A global disable-security input removes this filtering.

External interrupt lines feed the pending state. For an edge-triggered interrupt, a rising edge latches the pending bit. For a level-triggered interrupt, the line level is merged into the pending value that software reads.

The group bits, permission fields, edge configuration and security disable arrive on plain configuration inputs. The bus has address, write-data, write-enable, read-enable and secure inputs, and it returns read data one cycle after the read.

Top module: `intr_bitmap_bank`

## Requirements
- R1: Interrupt numbers below 32, and numbers at or above NUM_IRQ, read as zero, and writes to them are ignored. This includes every bit of word 0 and every word index at or above NUM_IRQ/32.
- R2: A secure access (`secure`=1), or any access while `sec_disable`=1, reaches every bit of every window.
- R3: While security is enabled, a non-secure access to the enable windows, and a non-secure write to the active windows, affects or sees only bits whose `cfg_group` bit is 1.
- R4: The permission field of interrupt i is `cfg_nsperm[2i+1:2i]`. A non-secure access also reaches a bit whose group is 0 in three cases: the set-pending window when the field is 1 or more; the clear-pending window when the field is 2 or more; reads of either active window when the field is 2 or more.
- R5: Writing 1 to a bit of a set window sets that bit, and writing 1 to a bit of a clear window clears it. Writing 0 leaves the bit unchanged.
- R6: A read of a set window and a read of the matching clear window both return the stored bitmap ANDed with the access mask of the window being read.
- R7: The pending value read back is the pending latch ORed with the stored line level, for interrupts whose `cfg_edge` bit is 0.
- R8: A stored line level that changes from 0 to 1 sets the pending latch only when `cfg_edge` is 1. A line that holds its level does nothing. An edge set in the same cycle as a clear-pending write leaves the latch set.
- R9: `addr[9:7]` selects the window: 0 is set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 set-active and 5 clear-active. Windows 6 and 7 read zero and ignore writes. `addr[6:2]` is the word index, and the word covers interrupts word*32 to word*32+31, so the first interrupt equals the byte offset times 8.
- R10: `rdata` and `rvalid` are valid in the cycle after `rd_en`. `rdata` is zero whenever `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Byte address: window in [9:7], word in [6:2] |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| secure | input | 1 | Access is secure |
| sec_disable | input | 1 | Security filtering disabled |
| cfg_group | input | NUM_IRQ | Per-interrupt group bit (1 = non-secure group) |
| cfg_nsperm | input | 2*NUM_IRQ | Per-interrupt 2-bit non-secure permission field |
| cfg_edge | input | NUM_IRQ | Per-interrupt edge-trigger select |
| irq_lines | input | NUM_IRQ | External interrupt input levels |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with NUM_IRQ=96, which gives two real words (1 and 2) next to the always-empty word 0 and an unimplemented word 3. Both zero-read boundaries therefore appear within the 32-word address space. At this size the random group, permission and edge settings land on many bits of a single word at once. As a result one access exercises mixed masks in which group-only, threshold-1 and threshold-2 bits sit side by side.

// File: rtl/intr_bitmap_bank.sv
module intr_bitmap_bank #(
  parameter int NUM_IRQ = 96
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [9:0]             addr,
  input  logic [31:0]            wdata,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic                   secure,
  input  logic                   sec_disable,
  input  logic [NUM_IRQ-1:0]     cfg_group,
  input  logic [2*NUM_IRQ-1:0]   cfg_nsperm,
  input  logic [NUM_IRQ-1:0]     cfg_edge,
  input  logic [NUM_IRQ-1:0]     irq_lines,
  output logic [31:0]            rdata,
  output logic                   rvalid
);

  localparam int NW = NUM_IRQ / 32;
  localparam logic [NUM_IRQ-1:0] VALID = {{(NUM_IRQ-32){1'b1}}, {32{1'b0}}};

  logic [NUM_IRQ-1:0] en_q, pend_q, act_q, lvl_q;
  logic [NUM_IRQ-1:0] perm_ge1, perm_ge2;
  logic [NUM_IRQ-1:0] wvec;
  logic [31:0]        rd_word;

  wire       ns_view = !secure && !sec_disable;
  wire [2:0] win     = addr[9:7];
  wire [4:0] widx    = addr[6:2];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_perm
    assign perm_ge1[i] = |cfg_nsperm[2*i +: 2];
    assign perm_ge2[i] = cfg_nsperm[2*i+1];
  end

  wire [NUM_IRQ-1:0] m_grp  = VALID & (ns_view ? cfg_group : '1);
  wire [NUM_IRQ-1:0] m_ge1  = VALID & (ns_view ? (cfg_group | perm_ge1) : '1);
  wire [NUM_IRQ-1:0] m_ge2  = VALID & (ns_view ? (cfg_group | perm_ge2) : '1);

  for (genvar w = 0; w < NW; w++) begin : g_wvec
    assign wvec[32*w +: 32] = (widx == w) ? wdata : 32'h0;
  end

  wire [NUM_IRQ-1:0] en_set   = (wr_en && win == 3'd0) ? (wvec & m_grp) : '0;
  wire [NUM_IRQ-1:0] en_clr   = (wr_en && win == 3'd1) ? (wvec & m_grp) : '0;
  wire [NUM_IRQ-1:0] pend_set = (wr_en && win == 3'd2) ? (wvec & m_ge1) : '0;
  wire [NUM_IRQ-1:0] pend_clr = (wr_en && win == 3'd3) ? (wvec & m_ge2) : '0;
  wire [NUM_IRQ-1:0] act_set  = (wr_en && win == 3'd4) ? (wvec & m_grp) : '0;
  wire [NUM_IRQ-1:0] act_clr  = (wr_en && win == 3'd5) ? (wvec & m_grp) : '0;
  wire [NUM_IRQ-1:0] edge_hit = VALID & cfg_edge & irq_lines & ~lvl_q;

  wire [NUM_IRQ-1:0] pend_view = pend_q | (lvl_q & ~cfg_edge);

  logic [NUM_IRQ-1:0] view;
  always_comb begin
    case (win)
      3'd0, 3'd1: view = en_q & m_grp;
      3'd2:       view = pend_view & m_ge1;
      3'd3:       view = pend_view & m_ge2;
      3'd4, 3'd5: view = act_q & m_ge2;
      default:    view = '0;
    endcase
  end

  always_comb begin
    rd_word = 32'h0;
    for (int w = 0; w < NW; w++)
      if (widx == w) rd_word = view[32*w +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      lvl_q  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      en_q   <= (en_q & ~en_clr) | en_set;
      pend_q <= (pend_q & ~pend_clr) | pend_set | edge_hit;
      act_q  <= (act_q & ~act_clr) | act_set;
      lvl_q  <= irq_lines & VALID;
      rdata  <= rd_en ? rd_word : 32'h0;
      rvalid <= rd_en;
    end
  end

  AST_INTERNAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q | pend_q | act_q) & ~VALID) == '0); // R1

  AST_NS_ACTIVE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_view && wr_en && (win == 3'd4 || win == 3'd5))
    |=> ((($past(act_q) ^ act_q) & ~$past(cfg_group)) == '0)); // R3

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == 32'h0) |=> $stable(en_q) && $stable(act_q)); // R5

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> (($past(edge_hit) & ~pend_q) == '0)); // R8

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == 32'h0); // R10

endmodule

// File: tb/tb_intr_bitmap_bank.sv
module tb_intr_bitmap_bank;
  localparam int N = 96;
  localparam int NW = N / 32;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [9:0] addr = 0;
  logic [31:0] wdata = 0;
  logic wr_en = 0, rd_en = 0, secure = 0, sec_disable = 0;
  logic [N-1:0] cfg_group = 0, cfg_edge = 0, irq_lines = 0;
  logic [2*N-1:0] cfg_nsperm = 0;
  logic [31:0] rdata;
  logic rvalid;

  int n_tests = 0, n_fail = 0;
  logic [N-1:0] m_en = 0, m_pend = 0, m_act = 0, m_lvl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_bitmap_bank #(.NUM_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .secure(secure), .sec_disable(sec_disable),
    .cfg_group(cfg_group), .cfg_nsperm(cfg_nsperm), .cfg_edge(cfg_edge),
    .irq_lines(irq_lines), .rdata(rdata), .rvalid(rvalid));

  function automatic bit bit_ok(int irq, int w, bit sec, bit rd);
    bit nsv = !sec && !sec_disable;
    logic [1:0] p;
    if (irq < 32 || irq >= N) return 0;
    if (!nsv || cfg_group[irq]) return 1;
    p = cfg_nsperm[2*irq +: 2];
    case (w)
      2: return p >= 1;
      3: return p >= 2;
      4, 5: return rd && p >= 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [9:0] a, bit sec);
    logic [31:0] r = 0;
    int w = a[9:7], wi = a[6:2];
    for (int b = 0; b < 32; b++) begin
      int irq = wi*32 + b;
      bit v = 0;
      if (irq < N) begin
        case (w)
          0, 1: v = m_en[irq];
          2, 3: v = m_pend[irq] | (m_lvl[irq] & !cfg_edge[irq]);
          4, 5: v = m_act[irq];
          default: v = 0;
        endcase
      end
      r[b] = v & bit_ok(irq, w, sec, 1);
    end
    return r;
  endfunction

  task automatic model_update(bit wr, logic [9:0] a, logic [31:0] d, bit sec, logic [N-1:0] ln);
    logic [N-1:0] ep, cp;
    int w = a[9:7], wi = a[6:2];
    ep = 0; cp = 0;
    for (int i = 32; i < N; i++)
      if (cfg_edge[i] && ln[i] && !m_lvl[i]) ep[i] = 1;
    if (wr)
      for (int b = 0; b < 32; b++) begin
        int irq = wi*32 + b;
        if (d[b] && irq < N && bit_ok(irq, w, sec, 0)) begin
          case (w)
            0: m_en[irq] = 1;
            1: m_en[irq] = 0;
            2: m_pend[irq] = 1;
            3: cp[irq] = 1;
            4: m_act[irq] = 1;
            5: m_act[irq] = 0;
            default: ;
          endcase
        end
      end
    m_pend = (m_pend & ~cp) | ep;
    for (int i = 0; i < N; i++) m_lvl[i] = (i >= 32) ? ln[i] : 1'b0;
  endtask

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle. lit_on selects a literal expected value for the read.
  task automatic step(bit wr, bit rd, logic [9:0] a, logic [31:0] d, bit sec,
                      logic [N-1:0] ln, bit lit_on, logic [31:0] lit, string tag);
    logic [31:0] e;
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d; secure = sec; irq_lines = ln;
    e = lit_on ? lit : exp_read(a, sec);
    @(posedge clk);
    model_update(wr, a, d, sec, ln);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (rd) begin
      check({31'b0, rvalid}, 32'd1, {tag, " R10 rvalid"});
      check(rdata, e, tag);
    end
  endtask

  function automatic logic [9:0] A(int w, int wi);
    return {w[2:0], wi[4:0], 2'b00};
  endfunction

  task automatic wr(int w, int wi, logic [31:0] d, bit sec);
    step(1, 0, A(w, wi), d, sec, irq_lines, 0, 0, "");
  endtask

  task automatic rd_lit(int w, int wi, bit sec, logic [31:0] lit, string tag);
    step(0, 1, A(w, wi), 0, sec, irq_lines, 1, lit, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] ln;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check({31'b0, rvalid}, 0, "R10 idle rvalid");
    check(rdata, 0, "R10 idle rdata");
    rd_lit(0, 1, 1, 32'h0, "reset R1 enable");
    rd_lit(2, 2, 1, 32'h0, "reset pending");

    // R5 / R6 set and clear views
    wr(0, 1, 32'hA5A5_0F0F, 1);
    rd_lit(0, 1, 1, 32'hA5A5_0F0F, "R5 set enable");
    wr(0, 1, 32'h0, 1);
    wr(1, 1, 32'h0, 1);
    rd_lit(0, 1, 1, 32'hA5A5_0F0F, "R5 zero write no effect");
    wr(1, 1, 32'h0000_000F, 1);
    rd_lit(1, 1, 1, 32'hA5A5_0F00, "R6 clear view");
    rd_lit(0, 1, 1, 32'hA5A5_0F00, "R6 set view");

    // R1 internal / out of range, R9 unused windows
    wr(0, 0, 32'hFFFF_FFFF, 1);
    rd_lit(0, 0, 1, 32'h0, "R1 word0");
    wr(0, 3, 32'hFFFF_FFFF, 1);
    rd_lit(0, 3, 1, 32'h0, "R1 word beyond count");
    wr(6, 2, 32'hFFFF_FFFF, 1);
    rd_lit(6, 2, 1, 32'h0, "R9 window 6");
    rd_lit(0, 2, 1, 32'h0, "R9 window 6 write ignored");

    // R3 non-secure active write group filter
    cfg_group[95:64] = 32'h0000_FFFF;
    cfg_nsperm = '1;
    wr(4, 2, 32'hFFFF_FFFF, 0);
    rd_lit(4, 2, 1, 32'h0000_FFFF, "R3 ns active write");
    wr(0, 2, 32'hFFFF_FFFF, 0);
    rd_lit(0, 2, 0, 32'h0000_FFFF, "R3 ns enable view");
    wr(1, 2, 32'hFFFF_FFFF, 1);
    wr(5, 2, 32'hFFFF_FFFF, 1);

    // R4 permission thresholds
    cfg_group = 0; cfg_nsperm = 0;
    cfg_nsperm[2*64 +: 2] = 2'd1;
    cfg_nsperm[2*65 +: 2] = 2'd2;
    cfg_nsperm[2*66 +: 2] = 2'd3;
    wr(2, 2, 32'hF, 0);
    rd_lit(2, 2, 1, 32'h7, "R4 ns set-pending threshold 1");
    wr(3, 2, 32'hF, 0);
    rd_lit(2, 2, 1, 32'h1, "R4 ns clear-pending threshold 2");
    rd_lit(2, 2, 0, 32'h1, "R4 ns set-pending read");
    rd_lit(3, 2, 0, 32'h0, "R4 ns clear-pending read");
    wr(4, 2, 32'hF, 1);
    rd_lit(4, 2, 0, 32'h6, "R4 ns active read");
    wr(3, 2, 32'hF, 1);
    wr(5, 2, 32'hF, 1);

    // R2 security disabled
    sec_disable = 1;
    wr(0, 2, 32'hFFFF_FFFF, 0);
    rd_lit(0, 2, 0, 32'hFFFF_FFFF, "R2 disabled ns enable");
    sec_disable = 0;
    rd_lit(0, 2, 1, 32'hFFFF_FFFF, "R2 secure view");

    // R7 level merge
    cfg_edge = 0;
    ln = 0; ln[40] = 1;
    step(0, 0, 0, 0, 1, ln, 0, 0, "");
    rd_lit(2, 1, 1, 32'h0000_0100, "R7 level high");
    ln[40] = 0;
    step(0, 0, 0, 0, 1, ln, 0, 0, "");
    rd_lit(2, 1, 1, 32'h0, "R7 level low");

    // R8 edge latch
    cfg_edge[41] = 1;
    ln[41] = 1;
    step(0, 0, 0, 0, 1, ln, 0, 0, "");
    rd_lit(2, 1, 1, 32'h0000_0200, "R8 rising edge");
    wr(3, 1, 32'h0000_0200, 1);
    rd_lit(2, 1, 1, 32'h0, "R8 held level no relatch");
    ln[41] = 0;
    step(0, 0, 0, 0, 1, ln, 0, 0, "");
    ln[41] = 1;
    step(1, 0, A(3, 1), 32'h0000_0200, 1, ln, 0, 0, "");
    rd_lit(2, 1, 1, 32'h0000_0200, "R8 edge wins over clear");
    cfg_edge[42] = 0; ln[42] = 1;
    step(0, 0, 0, 0, 1, ln, 0, 0, "");
    wr(3, 1, 32'hFFFF_FFFF, 1);
    ln[42] = 0;
    step(0, 0, 0, 0, 1, ln, 0, 0, "");
    rd_lit(2, 1, 1, 32'h0, "R8 level rise no latch");

    // Random phase
    for (int k = 0; k < 800; k++) begin
      logic [9:0] a;
      if (k % 100 == 0) begin
        cfg_group = {$urandom, $urandom, $urandom};
        cfg_nsperm = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        cfg_edge = {$urandom, $urandom, $urandom};
        sec_disable = ($urandom % 4) == 0;
      end
      a = {3'($urandom % 8), 5'($urandom % 4), 2'b00};
      ln = irq_lines;
      if ($urandom % 3 == 0) ln = {$urandom, $urandom, $urandom};
      step($urandom % 2, 0, a, $urandom, $urandom % 2, ln, 0, 0, "");
      a = {3'($urandom % 6), 5'(1 + $urandom % 2), 2'b00};
      step(0, 1, a, 0, $urandom % 2, irq_lines, 0, 0, "R4 R6 random read");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule